// File: doc/BRIEF.md
# Warp Load Coalescer

This block takes one load request covering all 32 lanes of a warp. The request holds a word-aligned byte address for every lane and a mask of the lanes that take part. The block gathers the active lanes into groups by 128-byte memory line and sends one transaction for each distinct line, one per cycle. Each transaction carries the line address, the lanes it serves, the 32-byte sectors it touches, each lane's word offset within the line, and a flag for lanes that share one word with another lane in the same transaction.

Requests arrive over a valid/ready handshake. Transactions leave over a valid/ready handshake too. The block takes no new request until the final transaction of the current one has been accepted. When the final transaction is accepted, the block reports how many transactions the request needed. When a contiguous warp access falls in a single line, it costs one transaction. When every lane hits a different line, it costs 32.

The control is a three-state machine. IDLE holds ready high. The transition IDLE→ISSUE happens on acceptance of a request with at least one active lane. The transition IDLE→EMPTY happens on acceptance of a request with no active lane. ISSUE→ISSUE happens on each accepted transaction that leaves lanes unserved. ISSUE→IDLE happens on acceptance of the final transaction. EMPTY→IDLE always happens after one cycle.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high in IDLE and low from the cycle after a request is accepted until the cycle after its final transaction is accepted. After that final acceptance it is high again.
- R2: Every lane set in `txn_lanes` has address bits [31:7] equal to `txn_line`. The number of transactions for a request equals the number of distinct lines among its active lanes.
- R3: The next transaction's line is taken from the lowest-numbered active lane not yet served. That transaction serves every unserved active lane in that line, and no lane is served twice.
- R4: When all active lanes lie in one line, exactly one transaction is issued, and its `txn_lanes` equals the request mask.
- R5: When every active lane lies in its own line, one transaction per lane is issued, up to 32, and each one serves a single lane.
- R6: Bit s of `txn_sectors` is set exactly when some served lane has address bits [6:5] equal to s. An aligned contiguous 32-word access gives 4'hF.
- R7: For every lane i, `txn_word_ofs[5i+4:5i]` equals that lane's address bits [6:2].
- R8: Bit i of `txn_bcast` is set exactly when lane i is served and another served lane in the same transaction has the identical address. Lanes that share an address add no transaction.
- R9: Lanes outside the mask are ignored. A request with an all-zero mask produces no transaction, and one cycle after acceptance it produces `done_valid` with `done_count` 0.
- R10: `done_valid` is high exactly in the cycle the final transaction is accepted, and `done_count` (6 bits) then holds the number of transactions issued. `txn_last` marks that final transaction.
- R11: While `txn_valid` is high and `txn_ready` is low, the transaction outputs hold their values.
- R12: When the address steps by one 4-byte element per lane from a line-aligned base, the request costs one transaction. When it steps by 32 or more elements, every lane costs its own transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits [32i+31:32i] |
| req_mask | input | 32 | Active-lane mask |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_line | output | 25 | Line address (byte address bits [31:7]) |
| txn_lanes | output | 32 | Lanes served by this transaction |
| txn_sectors | output | 4 | 32-byte sectors touched |
| txn_word_ofs | output | 160 | Word offset within the line for each lane, 5 bits per lane |
| txn_bcast | output | 32 | Served lanes that share their word with another served lane |
| txn_last | output | 1 | This is the final transaction of the request |
| done_valid | output | 1 | Request complete this cycle |
| done_count | output | 6 | Transactions issued for the request |

## Verification
The hardest cases to reach are those where the final transaction is stalled by downstream backpressure, and those where broadcast lanes, inactive lanes and several lines are mixed in one request. In those cases the ordering, the completion count and the stable-output rule all interact. The stimulus sweeps lane strides from zero to beyond one line, at aligned and unaligned bases. It then runs many random requests packed into four lines, so that shared addresses are common, with random masks and random stall patterns on `txn_ready`. Every transaction is compared with a reference sequence that the bench builds by grouping the lanes itself.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_EMPTY = 2'd2
    } coal_state_e;

endpackage

// File: rtl/coal_lead_pick.sv
// Lowest-numbered set bit of the pending mask.
module coal_lead_pick #(
    parameter int LANES = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pend,
    output logic [IDX_W-1:0] lead
);

    always_comb begin
        lead = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                lead = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/coal_line_match.sv
// Marks every pending lane whose line equals the leader's line.
module coal_line_match #(
    parameter int LANES  = 32,
    parameter int LINE_W = 25,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES*LINE_W-1:0] line_flat,
    input  logic [LANES-1:0]        pend,
    input  logic [IDX_W-1:0]        lead,
    output logic [LANES-1:0]        match,
    output logic [LINE_W-1:0]       lead_line
);

    always_comb begin
        lead_line = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lead == IDX_W'(i)) begin
                lead_line = line_flat[i*LINE_W +: LINE_W];
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign match[g] = pend[g] && (line_flat[g*LINE_W +: LINE_W] == lead_line);
    end

endmodule

// File: rtl/coal_txn_build.sv
// Sector mask, per-lane word offsets and broadcast flags for one transaction.
module coal_txn_build #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int OFS_W      = 7,
    parameter int SECT_SEL_W = 2,
    localparam int NSECT     = 1 << SECT_SEL_W,
    localparam int WOFS_W    = OFS_W - 2
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [LANES-1:0]        match,
    output logic [NSECT-1:0]        sectors,
    output logic [LANES*WOFS_W-1:0] word_ofs,
    output logic [LANES-1:0]        bcast
);

    always_comb begin
        sectors = '0;
        for (int i = 0; i < LANES; i++) begin
            if (match[i]) begin
                sectors[addr_flat[i*ADDR_W + OFS_W - SECT_SEL_W +: SECT_SEL_W]] = 1'b1;
            end
        end
    end

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        logic [LANES-1:0] same;
        assign word_ofs[gi*WOFS_W +: WOFS_W] = addr_flat[gi*ADDR_W + 2 +: WOFS_W];
        for (genvar gj = 0; gj < LANES; gj++) begin : g_peer
            if (gi == gj) begin : g_self
                assign same[gj] = 1'b0;
            end else begin : g_other
                assign same[gj] = match[gj] &&
                    (addr_flat[gj*ADDR_W +: ADDR_W] == addr_flat[gi*ADDR_W +: ADDR_W]);
            end
        end
        assign bcast[gi] = match[gi] && (|same);
    end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int SECTORS    = 4,
    localparam int OFS_W      = $clog2(LINE_BYTES),
    localparam int LINE_W     = ADDR_W - OFS_W,
    localparam int SECT_SEL_W = $clog2(SECTORS),
    localparam int IDX_W      = $clog2(LANES),
    localparam int CNT_W      = $clog2(LANES) + 1,
    localparam int WOFS_W     = OFS_W - 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [LANES*ADDR_W-1:0]  req_addr,
    input  logic [LANES-1:0]         req_mask,
    output logic                     txn_valid,
    input  logic                     txn_ready,
    output logic [LINE_W-1:0]        txn_line,
    output logic [LANES-1:0]         txn_lanes,
    output logic [SECTORS-1:0]       txn_sectors,
    output logic [LANES*WOFS_W-1:0]  txn_word_ofs,
    output logic [LANES-1:0]         txn_bcast,
    output logic                     txn_last,
    output logic                     done_valid,
    output logic [CNT_W-1:0]         done_count
);

    import coal_pkg::*;

    coal_state_e state_q, state_d;

    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        pend_q;
    logic [CNT_W-1:0]        cnt_q;

    logic [LANES*LINE_W-1:0] line_flat;
    logic [IDX_W-1:0]        lead;
    logic [LANES-1:0]        match;
    logic [LINE_W-1:0]       lead_line;
    logic                    accept;
    logic                    hs;
    logic                    final_txn;

    for (genvar g = 0; g < LANES; g++) begin : g_line
        assign line_flat[g*LINE_W +: LINE_W] = addr_q[g*ADDR_W + OFS_W +: LINE_W];
    end

    coal_lead_pick #(.LANES(LANES)) i_pick (
        .pend (pend_q),
        .lead (lead)
    );

    coal_line_match #(.LANES(LANES), .LINE_W(LINE_W)) i_match (
        .line_flat (line_flat),
        .pend      (pend_q),
        .lead      (lead),
        .match     (match),
        .lead_line (lead_line)
    );

    coal_txn_build #(
        .LANES(LANES), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SECT_SEL_W(SECT_SEL_W)
    ) i_build (
        .addr_flat (addr_q),
        .match     (match),
        .sectors   (txn_sectors),
        .word_ofs  (txn_word_ofs),
        .bcast     (txn_bcast)
    );

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign hs        = (state_q == ST_ISSUE) && txn_ready;
    assign final_txn = ((pend_q & ~match) == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (req_mask == '0) ? ST_EMPTY : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (txn_ready && final_txn) begin
                    state_d = ST_IDLE;
                end
            end
            ST_EMPTY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Request data path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            pend_q <= '0;
            cnt_q  <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            pend_q <= req_mask;
            cnt_q  <= '0;
        end else if (hs) begin
            pend_q <= pend_q & ~match;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        txn_valid  = 1'b0;
        txn_last   = 1'b0;
        done_valid = 1'b0;
        done_count = '0;
        txn_line   = lead_line;
        txn_lanes  = match;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_ISSUE: begin
                txn_valid  = 1'b1;
                txn_last   = final_txn;
                done_valid = txn_ready && final_txn;
                done_count = cnt_q + 1'b1;
            end
            ST_EMPTY: done_valid = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int LANES   = 32,
    parameter int LINE_W  = 25,
    parameter int SECTORS = 4,
    parameter int CNT_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               txn_valid,
    input logic               txn_ready,
    input logic [LINE_W-1:0]  txn_line,
    input logic [LANES-1:0]   txn_lanes,
    input logic [SECTORS-1:0] txn_sectors,
    input logic [LANES-1:0]   txn_bcast,
    input logic               txn_last,
    input logic               done_valid,
    input logic [CNT_W-1:0]   done_count
);

    logic [LANES-1:0] served_q;
    logic [CNT_W-1:0] hs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            served_q <= '0;
            hs_q     <= '0;
        end else if (req_valid && req_ready) begin
            served_q <= '0;
            hs_q     <= '0;
        end else if (txn_valid && txn_ready) begin
            served_q <= served_q | txn_lanes;
            hs_q     <= hs_q + 1'b1;
        end
    end

    p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready);

    p_accept_drops_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_txn_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes != '0) && (txn_sectors != '0));

    p_no_reserve_r3: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((served_q & txn_lanes) == '0));

    p_sector_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ($countones(txn_sectors) <= $countones(txn_lanes)));

    p_bcast_served_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_bcast & ~txn_lanes) == '0));

    p_empty_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !txn_valid) |-> (done_count == '0));

    p_last_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready && txn_last) |-> done_valid);

    p_count_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && txn_valid) |-> (done_count == hs_q + 1'b1));

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> txn_valid && $stable(txn_line) && $stable(txn_lanes)
            && $stable(txn_sectors));

endmodule

bind warp_coalescer coal_checker #(
    .LANES(LANES), .LINE_W(LINE_W), .SECTORS(SECTORS), .CNT_W(CNT_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .txn_valid   (txn_valid),
    .txn_ready   (txn_ready),
    .txn_line    (txn_line),
    .txn_lanes   (txn_lanes),
    .txn_sectors (txn_sectors),
    .txn_bcast   (txn_bcast),
    .txn_last    (txn_last),
    .done_valid  (done_valid),
    .done_count  (done_count)
);

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req_valid;
    logic            req_ready;
    logic [NL*32-1:0] req_addr;
    logic [NL-1:0]   req_mask;
    logic            txn_valid;
    logic            txn_ready;
    logic [24:0]     txn_line;
    logic [NL-1:0]   txn_lanes;
    logic [3:0]      txn_sectors;
    logic [NL*5-1:0] txn_word_ofs;
    logic [NL-1:0]   txn_bcast;
    logic            txn_last;
    logic            done_valid;
    logic [5:0]      done_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_coalescer i_warp_coalescer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_line(txn_line), .txn_lanes(txn_lanes),
        .txn_sectors(txn_sectors), .txn_word_ofs(txn_word_ofs),
        .txn_bcast(txn_bcast), .txn_last(txn_last),
        .done_valid(done_valid), .done_count(done_count)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] t_addr [NL];
    logic [NL-1:0] t_mask;

    logic [24:0]   e_line  [NL];
    logic [NL-1:0] e_lanes [NL];
    logic [3:0]    e_sect  [NL];
    logic [NL-1:0] e_bcast [NL];
    int            e_n;

    int            obs_count;
    logic [3:0]    obs_sect0;
    logic [NL-1:0] obs_bcast0;
    logic [NL-1:0] obs_lanes0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Reference grouping: lowest unserved lane picks the line.
    task automatic build_expected();
        logic [NL-1:0] pend;
        pend = t_mask;
        e_n  = 0;
        while (pend != '0) begin
            int lead = 0;
            logic [24:0] ln;
            for (int i = NL - 1; i >= 0; i--) if (pend[i]) lead = i;
            ln = t_addr[lead][31:7];
            e_line[e_n]  = ln;
            e_lanes[e_n] = '0;
            e_sect[e_n]  = '0;
            e_bcast[e_n] = '0;
            for (int i = 0; i < NL; i++) begin
                if (pend[i] && t_addr[i][31:7] == ln) begin
                    e_lanes[e_n][i] = 1'b1;
                    e_sect[e_n][t_addr[i][6:5]] = 1'b1;
                end
            end
            for (int i = 0; i < NL; i++) begin
                for (int j = 0; j < NL; j++) begin
                    if (i != j && e_lanes[e_n][i] && e_lanes[e_n][j] && t_addr[i] == t_addr[j])
                        e_bcast[e_n][i] = 1'b1;
                end
            end
            pend = pend & ~e_lanes[e_n];
            e_n++;
        end
    endtask

    // stall_mode: 0 always ready, 1 alternate, 2 random
    task automatic run_req(input int stall_mode);
        int k = 0;
        int cyc = 0;
        bit have_snap = 0;
        logic [24:0]   snap_line;
        logic [NL-1:0] snap_lanes;
        build_expected();
        obs_count = -1;
        @(negedge clk);
        for (int i = 0; i < NL; i++) req_addr[i*32 +: 32] = t_addr[i];
        req_mask  = t_mask;
        req_valid = 1'b1;
        txn_ready = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R1", "ready before accept", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (e_n == 0) begin
            #1;
            chk(done_valid == 1'b1 && txn_valid == 1'b0, "R9", "empty completion",
                {done_valid, txn_valid}, 2'b10);
            chk(done_count == 6'd0, "R9", "empty count", done_count, 0);
            obs_count = done_count;
            @(negedge clk);
            #1;
            chk(req_ready == 1'b1, "R1", "ready after empty", req_ready, 1);
            return;
        end
        while (k < e_n && cyc < 3000) begin
            case (stall_mode)
                0: txn_ready = 1'b1;
                1: txn_ready = cyc[0];
                default: txn_ready = ($urandom % 3) != 0;
            endcase
            #1;
            if (have_snap) begin
                chk(txn_line == snap_line && txn_lanes == snap_lanes, "R11", "held while stalled",
                    {txn_line, txn_lanes}, {snap_line, snap_lanes});
                have_snap = 0;
            end
            chk(txn_valid == 1'b1 && req_ready == 1'b0, "R1", "busy valid/ready",
                {txn_valid, req_ready}, 2'b10);
            if (txn_ready) begin
                bit ofs_ok = 1;
                chk(txn_line == e_line[k], "R2", "line", txn_line, e_line[k]);
                chk(txn_lanes == e_lanes[k], "R3", "lanes", txn_lanes, e_lanes[k]);
                chk(txn_sectors == e_sect[k], "R6", "sectors", txn_sectors, e_sect[k]);
                chk(txn_bcast == e_bcast[k], "R8", "broadcast", txn_bcast, e_bcast[k]);
                for (int i = 0; i < NL; i++)
                    if (t_mask[i] && txn_word_ofs[i*5 +: 5] != t_addr[i][6:2]) ofs_ok = 0;
                chk(ofs_ok, "R7", "word offsets", ofs_ok, 1);
                chk(txn_last == (k == e_n - 1) && done_valid == (k == e_n - 1), "R10",
                    "last/done flags", {txn_last, done_valid}, {2{k == e_n - 1}});
                if (k == 0) begin
                    obs_sect0  = txn_sectors;
                    obs_bcast0 = txn_bcast;
                    obs_lanes0 = txn_lanes;
                end
                if (k == e_n - 1) begin
                    chk(done_count == 6'(e_n), "R10", "count", done_count, e_n);
                    obs_count = done_count;
                end
                k++;
            end else begin
                chk(done_valid == 1'b0, "R10", "no done while stalled", done_valid, 0);
                snap_line  = txn_line;
                snap_lanes = txn_lanes;
                have_snap  = 1;
            end
            cyc++;
            @(negedge clk);
        end
        txn_ready = 1'b0;
        #1;
        chk(req_ready == 1'b1 && txn_valid == 1'b0, "R1", "ready after final",
            {req_ready, txn_valid}, 2'b10);
    endtask

    task automatic set_stride(input logic [31:0] base, input int stride);
        for (int i = 0; i < NL; i++) t_addr[i] = base + 32'(4 * stride * i);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int strides [12] = '{0, 1, 2, 3, 4, 8, 16, 31, 32, 33, 64, 100};
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_addr = '0;
        req_mask = '0;
        txn_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 1'b1 && txn_valid == 1'b0 && done_valid == 1'b0, "R1",
            "reset state", {req_ready, txn_valid, done_valid}, 3'b100);
        rst_n = 1'b1;

        // R4 R6 R12: aligned unit stride, one line, all sectors
        set_stride(32'h1000, 1); t_mask = '1; run_req(0);
        chk(obs_count == 1, "R4", "unit stride count", obs_count, 1);
        chk(obs_lanes0 == '1, "R4", "unit stride lanes", obs_lanes0, 32'hFFFF_FFFF);
        chk(obs_sect0 == 4'hF, "R6", "unit stride sectors", obs_sect0, 4'hF);
        chk(obs_count == 1, "R12", "stride 1 single line", obs_count, 1);

        // R5 R12: stride of one row (32 elements) -> 32 transactions
        set_stride(32'h8000, 32); t_mask = '1; run_req(1);
        chk(obs_count == 32, "R5", "row stride count", obs_count, 32);
        chk($countones(obs_lanes0) == 1, "R5", "single lane per txn", obs_lanes0, 1);
        set_stride(32'h8000, 100); t_mask = '1; run_req(0);
        chk(obs_count == 32, "R12", "stride 100 count", obs_count, 32);

        // R8: all lanes same address -> one txn, every lane broadcast
        set_stride(32'h2040, 0); t_mask = '1; run_req(0);
        chk(obs_count == 1, "R8", "broadcast count", obs_count, 1);
        chk(obs_bcast0 == '1, "R8", "broadcast flags", obs_bcast0, 32'hFFFF_FFFF);

        // Stride 2 aligned spans exactly two lines
        set_stride(32'h3000, 2); t_mask = '1; run_req(2);
        chk(obs_count == 2, "R2", "stride 2 count", obs_count, 2);

        // R9: inactive lanes on far lines are ignored
        set_stride(32'h8000, 32); t_mask = 32'h0101_0101; run_req(0);
        chk(obs_count == 4, "R9", "masked row stride", obs_count, 4);
        set_stride(32'h8000, 32); t_mask = 32'h0002_0000; run_req(1);
        chk(obs_count == 1 && obs_lanes0 == 32'h0002_0000, "R9", "single lane",
            obs_lanes0, 32'h0002_0000);
        t_mask = '0; run_req(0);
        chk(obs_count == 0, "R9", "zero mask", obs_count, 0);

        // Stride sweep at aligned and unaligned bases
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 12; s++) begin
                set_stride(b == 0 ? 32'h0001_0000 : 32'h0001_0044, strides[s]);
                t_mask = '1;
                run_req(s % 3);
            end
        end

        // Random requests packed into four lines
        for (int r = 0; r < 80; r++) begin
            for (int i = 0; i < NL; i++)
                t_addr[i] = 32'h0004_0000 + 32'(($urandom % 4) * 128) + 32'(($urandom % 32) * 4);
            t_mask = (r % 10 == 0) ? '1 : $urandom;
            run_req(r % 3);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule